// File: doc/BRIEF.md
# Streaming Complex Power Calculator

This block follows a transform stage. It accepts complex frequency bins, one per AXI4-Stream beat. It returns the power of each bin, the sum of the squared real and imaginary parts, as an unsigned word on an AXI4-Stream master port. It takes no square root. The next stage only ranks bins against each other or against a threshold, so the power is enough and the root would cost area for nothing.

The arithmetic runs as a pipeline. The squarers come first, then the adder, then an optional set of output registers. A shadow pipeline of valid and frame-end flags moves in lockstep with the data. Backpressure from the master side stalls the whole pipeline and stops new input, so beats are never lost or repeated. The end-of-frame marker always comes out on the result of the beat that carried it. Parameters set the component width, the number of extra output registers and the squarer variant: a signed multiply, or a magnitude-then-unsigned multiply.

Top module: `cpow_power_stream`

## Requirements
- R1: An input word is read as two two's-complement fields. The real part is `s_axis_tdata[15:0]` and the imaginary part is `s_axis_tdata[31:16]`.
- R2: `m_axis_tdata` equals real*real + imag*imag as an unsigned 32-bit value. The extreme case, both parts at -32768, gives 0x8000_0000.
- R3: With `m_axis_tready` held high, the result of a beat accepted at clock edge k is presented as valid after edge k+LAT. LAT is 2 + EXTRA_REGS, which is 2 by default.
- R4: `m_axis_tlast` is high exactly on the output beat whose input beat had `s_axis_tlast` high, and it is never high without `m_axis_tvalid`.
- R5: While `m_axis_tvalid` is high and `m_axis_tready` is low, `m_axis_tvalid`, `m_axis_tdata` and `m_axis_tlast` hold their values on the next cycle.
- R6: `s_axis_tready` is low whenever `m_axis_tvalid` is high and `m_axis_tready` is low, and high otherwise.
- R7: Under any pattern of input gaps and output backpressure, every accepted beat produces exactly one output beat, in order of acceptance.
- R8: After reset, `m_axis_tvalid` is low and `s_axis_tready` is high. No output appears until an input beat is accepted.
- R9: A cycle with `s_axis_tvalid` low consumes nothing, whatever sits on `s_axis_tdata` and `s_axis_tlast`, and produces no output beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| aclk | input | 1 | Clock |
| aresetn | input | 1 | Active-low synchronous reset |
| s_axis_tvalid | input | 1 | Input beat valid |
| s_axis_tready | output | 1 | Block can accept an input beat |
| s_axis_tdata | input | 32 | Packed complex bin: imaginary high half, real low half |
| s_axis_tlast | input | 1 | Input beat is the last of a frame |
| m_axis_tvalid | output | 1 | Output power valid |
| m_axis_tready | input | 1 | Downstream accepts the output beat |
| m_axis_tdata | output | 32 | Unsigned power of the bin |
| m_axis_tlast | output | 1 | Output beat is the last of a frame |

## Verification
A corrupted valid or frame-end shadow bit shows at the ports within LAT cycles, in one of three ways: a missing or extra result, a frame marker on the wrong beat, or a changed count of results against the scoreboard queue. A stall that fails to freeze every stage shows on the next cycle of backpressure, either as output data that moves while held or as a beat skipped in the in-order comparison. An error in the arithmetic or the field packing shows on the first beat that exercises it. The bench covers this with directed extreme values, mixed signs and randomized bins.

// File: rtl/cpow_pkg.sv
package cpow_pkg;

   localparam int unsigned CPOW_MAX_EXTRA = 4;

   typedef enum logic [0:0] {
      SQ_SIGNED_MUL = 1'b0,
      SQ_MAG_MUL    = 1'b1
   } sq_style_e;

   function automatic int unsigned cpow_latency(input int unsigned extra_regs);
      return 2 + extra_regs;
   endfunction

endpackage

// File: rtl/cpow_squarer.sv
module cpow_squarer
   import cpow_pkg::*;
#(
   parameter int unsigned W        = 16,
   parameter sq_style_e   SQ_STYLE = SQ_SIGNED_MUL,
   localparam int unsigned PW      = 2 * W
)(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          en,
   input  logic [W-1:0]  a,
   output logic [PW-1:0] sq
);

   logic [PW-1:0] prod;

   generate
      if (SQ_STYLE == SQ_SIGNED_MUL) begin : g_signed
         logic signed [PW-1:0] ax;
         always_comb begin
            ax   = $signed({{W{a[W-1]}}, a});
            prod = $unsigned(ax * ax);
         end
      end else begin : g_mag
         logic [W-1:0]  mag;
         logic [PW-1:0] mx;
         always_comb begin
            mag  = a[W-1] ? (~a + 1'b1) : a;
            mx   = {{W{1'b0}}, mag};
            prod = mx * mx;
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sq <= '0;
      end else if (en) begin
         sq <= prod;
      end
   end

   // R2: a square of a W-bit signed value never reaches the top product bit
   p_sq_top_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
      sq[PW-1] == 1'b0);

endmodule

// File: rtl/cpow_sum.sv
module cpow_sum #(
   parameter int unsigned W          = 32,
   parameter int unsigned EXTRA_REGS = 0
)(
   input  logic         clk,
   input  logic         rst_n,
   input  logic         en,
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   output logic [W-1:0] y
);

   localparam logic [W-1:0] BOUND = {1'b1, {(W-1){1'b0}}};

   logic [W-1:0] pipe [0:EXTRA_REGS];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pipe[0] <= '0;
      end else if (en) begin
         pipe[0] <= a + b;
      end
   end

   generate
      for (genvar i = 1; i <= EXTRA_REGS; i++) begin : g_out_reg
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               pipe[i] <= '0;
            end else if (en) begin
               pipe[i] <= pipe[i-1];
            end
         end
      end
   endgenerate

   assign y = pipe[EXTRA_REGS];

   // R2: sum of two squares of signed halves never exceeds 2^(W-1)
   p_sum_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
      pipe[0] <= BOUND);

endmodule

// File: rtl/cpow_flow_ctl.sv
module cpow_flow_ctl #(
   parameter int unsigned LAT = 2
)(
   input  logic clk,
   input  logic rst_n,
   input  logic in_valid,
   input  logic in_last,
   output logic in_ready,
   output logic adv,
   output logic out_valid,
   output logic out_last,
   input  logic out_ready
)
;
   logic [LAT-1:0] vld_sh;
   logic [LAT-1:0] lst_sh;

   assign adv       = !(vld_sh[LAT-1] && !out_ready);
   assign in_ready  = adv;
   assign out_valid = vld_sh[LAT-1];
   assign out_last  = lst_sh[LAT-1];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld_sh[0] <= 1'b0;
         lst_sh[0] <= 1'b0;
      end else if (adv) begin
         vld_sh[0] <= in_valid;
         lst_sh[0] <= in_valid & in_last;
      end
   end

   generate
      for (genvar i = 1; i < LAT; i++) begin : g_shadow
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               vld_sh[i] <= 1'b0;
               lst_sh[i] <= 1'b0;
            end else if (adv) begin
               vld_sh[i] <= vld_sh[i-1];
               lst_sh[i] <= lst_sh[i-1];
            end
         end
      end
   endgenerate

   // R7: an output beat only appears after its predecessor stage held a beat
   p_rise_from_prev_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(vld_sh[LAT-1]) |-> $past(vld_sh[LAT-2]));

   // R4: frame end is never flagged on an empty output slot
   p_last_with_valid_r4: assert property (@(posedge clk) disable iff (!rst_n)
      out_last |-> out_valid);

endmodule

// File: rtl/cpow_power_stream.sv
module cpow_power_stream
   import cpow_pkg::*;
#(
   parameter int unsigned COMP_W     = 16,
   parameter int unsigned EXTRA_REGS = 0,
   parameter sq_style_e   SQ_STYLE   = SQ_SIGNED_MUL,
   localparam int unsigned IN_W      = 2 * COMP_W,
   localparam int unsigned OUT_W     = 2 * COMP_W,
   localparam int unsigned LAT       = cpow_latency(EXTRA_REGS)
)(
   input  logic             aclk,
   input  logic             aresetn,
   input  logic             s_axis_tvalid,
   output logic             s_axis_tready,
   input  logic [IN_W-1:0]  s_axis_tdata,
   input  logic             s_axis_tlast,
   output logic             m_axis_tvalid,
   input  logic             m_axis_tready,
   output logic [OUT_W-1:0] m_axis_tdata,
   output logic             m_axis_tlast
);

   generate
      if (COMP_W < 2 || COMP_W > 32) begin : g_bad_width
         $error("cpow_power_stream: COMP_W must lie in 2..32");
      end
      if (EXTRA_REGS > CPOW_MAX_EXTRA) begin : g_bad_extra
         $error("cpow_power_stream: EXTRA_REGS exceeds the supported maximum");
      end
   endgenerate

   logic             adv;
   logic [OUT_W-1:0] sq_re;
   logic [OUT_W-1:0] sq_im;

   // R1: real part in the low half, imaginary part in the high half
   logic [COMP_W-1:0] f_re;
   logic [COMP_W-1:0] f_im;
   assign f_re = s_axis_tdata[COMP_W-1:0];
   assign f_im = s_axis_tdata[IN_W-1:COMP_W];

   cpow_flow_ctl #(.LAT(LAT)) u_ctl (
      .clk       (aclk),
      .rst_n     (aresetn),
      .in_valid  (s_axis_tvalid),
      .in_last   (s_axis_tlast),
      .in_ready  (s_axis_tready),
      .adv       (adv),
      .out_valid (m_axis_tvalid),
      .out_last  (m_axis_tlast),
      .out_ready (m_axis_tready)
   );

   cpow_squarer #(.W(COMP_W), .SQ_STYLE(SQ_STYLE)) u_sq_re (
      .clk   (aclk),
      .rst_n (aresetn),
      .en    (adv),
      .a     (f_re),
      .sq    (sq_re)
   );

   cpow_squarer #(.W(COMP_W), .SQ_STYLE(SQ_STYLE)) u_sq_im (
      .clk   (aclk),
      .rst_n (aresetn),
      .en    (adv),
      .a     (f_im),
      .sq    (sq_im)
   );

   cpow_sum #(.W(OUT_W), .EXTRA_REGS(EXTRA_REGS)) u_sum (
      .clk   (aclk),
      .rst_n (aresetn),
      .en    (adv),
      .a     (sq_re),
      .b     (sq_im),
      .y     (m_axis_tdata)
   );

   // R5: a held output beat keeps its value
   p_hold_out_r5: assert property (@(posedge aclk) disable iff (!aresetn)
      (m_axis_tvalid && !m_axis_tready) |=>
         (m_axis_tvalid && $stable(m_axis_tdata) && $stable(m_axis_tlast)));

   // R6: no input accepted while the output is blocked
   p_stall_blocks_in_r6: assert property (@(posedge aclk) disable iff (!aresetn)
      (m_axis_tvalid && !m_axis_tready) |-> !s_axis_tready);

endmodule

// File: tb/cpow_power_stream_tb_top.sv
module cpow_power_stream_tb_top;

   localparam int LAT = 2;

   logic        aclk = 1'b0;
   logic        aresetn = 1'b0;
   logic        s_axis_tvalid = 1'b0;
   logic        s_axis_tready;
   logic [31:0] s_axis_tdata = '0;
   logic        s_axis_tlast = 1'b0;
   logic        m_axis_tvalid;
   logic        m_axis_tready = 1'b1;
   logic [31:0] m_axis_tdata;
   logic        m_axis_tlast;

   int n_cmp = 0;
   int n_bad = 0;
   int n_in  = 0;
   int n_out = 0;
   bit bp_en = 1'b0;
   bit mon_en = 1'b0;
   bit hold_pend = 1'b0;
   logic [31:0] hold_data;
   logic        hold_last;
   logic [32:0] exp_q [$];

   always #4 aclk = ~aclk;

   cpow_power_stream dut_i (
      .aclk          (aclk),
      .aresetn       (aresetn),
      .s_axis_tvalid (s_axis_tvalid),
      .s_axis_tready (s_axis_tready),
      .s_axis_tdata  (s_axis_tdata),
      .s_axis_tlast  (s_axis_tlast),
      .m_axis_tvalid (m_axis_tvalid),
      .m_axis_tready (m_axis_tready),
      .m_axis_tdata  (m_axis_tdata),
      .m_axis_tlast  (m_axis_tlast)
   );

   function automatic logic [31:0] ref_pow(input logic [31:0] w);
      longint re = longint'($signed(w[15:0]));
      longint im = longint'($signed(w[31:16]));
      longint p  = re * re + im * im;
      return p[31:0];
   endfunction

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   // backpressure source
   initial begin
      forever begin
         @(posedge aclk);
         #1;
         m_axis_tready = bp_en ? 1'($urandom_range(0, 1)) : 1'b1;
      end
   end

   // monitor / scoreboard
   always @(negedge aclk) begin
      if (mon_en && aresetn) begin
         if (hold_pend) begin
            // R5: held beat unchanged
            check(m_axis_tvalid && m_axis_tdata == hold_data && m_axis_tlast == hold_last,
                  "R5", {m_axis_tvalid, m_axis_tlast, m_axis_tdata}, {1'b1, hold_last, hold_data});
         end
         hold_pend = 1'b0;
         if (m_axis_tvalid && !m_axis_tready) begin
            // R6: input blocked during output stall
            check(!s_axis_tready, "R6", s_axis_tready, 0);
            hold_pend = 1'b1;
            hold_data = m_axis_tdata;
            hold_last = m_axis_tlast;
         end
         if (m_axis_tvalid && m_axis_tready) begin
            n_out++;
            if (exp_q.size() == 0) begin
               // R7: no extra beat
               check(1'b0, "R7", m_axis_tdata, 0);
            end else begin
               logic [32:0] e;
               e = exp_q.pop_front();
               // R2 value, R4 frame marker, R7 order
               check(m_axis_tdata == e[31:0], "R2/R7", m_axis_tdata, e[31:0]);
               check(m_axis_tlast == e[32], "R4", m_axis_tlast, e[32]);
            end
         end
      end
   end

   task automatic send(input logic [31:0] d, input bit last, input int gap);
      for (int g = 0; g < gap; g++) begin
         s_axis_tvalid = 1'b0;
         s_axis_tdata  = $urandom;
         s_axis_tlast  = 1'($urandom_range(0, 1));
         @(posedge aclk);
         #1;
      end
      s_axis_tvalid = 1'b1;
      s_axis_tdata  = d;
      s_axis_tlast  = last;
      @(negedge aclk);
      while (!s_axis_tready) @(negedge aclk);
      exp_q.push_back({last, ref_pow(d)});
      n_in++;
      @(posedge aclk);
      #1;
      s_axis_tvalid = 1'b0;
      s_axis_tlast  = 1'b0;
   endtask

   task automatic drain();
      int t = 0;
      while (exp_q.size() != 0 && t < 1000) begin
         @(posedge aclk);
         t++;
      end
      repeat (4) @(posedge aclk);
      #1;
   endtask

   initial begin
      repeat (150000) @(posedge aclk);
      n_bad++;
      $display("FAIL watchdog actual=running expected=done");
      finish_run();
   end

   initial begin
      repeat (3) @(posedge aclk);
      @(negedge aclk);
      // R8: reset state
      check(!m_axis_tvalid, "R8", m_axis_tvalid, 0);
      aresetn = 1'b1;
      @(posedge aclk);
      #1;
      repeat (3) begin
         @(negedge aclk);
         check(!m_axis_tvalid && s_axis_tready, "R8", {m_axis_tvalid, s_axis_tready}, 2'b01);
      end
      @(posedge aclk);
      #1;
      mon_en = 1'b1;

      // R3: latency with ready held high
      begin
         int cnt = 0;
         s_axis_tvalid = 1'b1;
         s_axis_tdata  = {16'd4, 16'd3};
         s_axis_tlast  = 1'b1;
         @(negedge aclk);
         exp_q.push_back({1'b1, 32'd25});
         n_in++;
         @(posedge aclk);
         #1;
         s_axis_tvalid = 1'b0;
         s_axis_tlast  = 1'b0;
         while (!m_axis_tvalid && cnt < 20) begin
            @(negedge aclk);
            cnt++;
         end
         check(cnt == LAT, "R3", cnt, LAT);
      end
      drain();

      // R1/R2: directed extremes and signs
      send({16'h8000, 16'h8000}, 1'b0, 0);   // R2 -> 0x8000_0000
      send({16'h7FFF, 16'h8000}, 1'b0, 0);
      send({16'h0000, 16'h0000}, 1'b0, 1);
      send({16'h0001, 16'hFFFF}, 1'b0, 0);   // R1: -1 real, 1 imag -> 2
      send({16'hFFFD, 16'h0000}, 1'b1, 0);   // R1: imag only, -3 -> 9
      send({16'h0000, 16'h0005}, 1'b0, 2);   // R1: real only -> 25
      drain();

      // R9: idle cycles with noise on the bus produce nothing
      for (int i = 0; i < 12; i++) begin
         s_axis_tvalid = 1'b0;
         s_axis_tdata  = $urandom;
         s_axis_tlast  = 1'b1;
         @(negedge aclk);
         check(!m_axis_tvalid, "R9", m_axis_tvalid, 0);
         @(posedge aclk);
         #1;
      end
      s_axis_tlast = 1'b0;

      // R7/R4/R5/R6: random frames under backpressure
      bp_en = 1'b1;
      for (int f = 0; f < 40; f++) begin
         for (int b = 0; b < 8; b++) begin
            send($urandom, b == 7, $urandom_range(0, 2));
         end
      end
      for (int b = 0; b < 60; b++) begin
         send($urandom, 1'($urandom_range(0, 1)), 0);
      end
      bp_en = 1'b0;
      drain();

      // R7: every accepted beat came out exactly once
      check(exp_q.size() == 0 && n_in == n_out, "R7", n_out, n_in);
      finish_run();
   end

endmodule